// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Software Refill

This block is a small fully associative translation buffer that maps virtual page numbers to physical page numbers. Its contents are managed by software: when a lookup finds nothing usable, the block reports a miss, and the exception handler installs a new entry through a write port at an index of its choice. A victim output suggests which index to overwrite. The block has no page-table walker.

Each entry carries an address-space tag. A non-global entry translates only for the address space held in the current-ASID register. A global entry translates for every address space, so one entry can serve a page shared by all processes. Loading a new ASID on a context switch removes no entries, so older translations become usable again when their address space returns. While the processor is in exception mode, translation is off and the virtual page passes straight through. A miss handler therefore cannot miss itself. A supervisor-only protection bit makes a user-mode access fault instead of translate.

The victim hint first picks an entry whose address space is no longer current. If there is none, it picks the entry that has gone unused for the longest time, based on per-entry saturating age counters.

Top module: `asid_tlb`

## Requirements
- R1: After reset, or in the cycle after `flush_all`, every entry is invalid. A translated lookup then misses and `victim_idx` is 0. When `flush_all` and `wr_en` are high in the same cycle, the flush wins and the write is dropped.
- R2: The result of a lookup appears with `res_valid` high exactly one cycle after `lk_req`. `res_valid` is low in every other cycle. At most one of `res_hit`, `res_miss`, `res_fault` is high, and all three are low when `res_valid` is low.
- R3: A non-global entry matches only when it is valid, its VPN equals `lk_vpn`, and its ASID tag equals `cur_asid`. A lookup with no matching entry gives `res_miss`, with `res_ppn` and `res_prot` both 0.
- R4: A valid global entry matches on VPN alone, whatever the value of `cur_asid`.
- R5: A write with `asid_we` loads `asid_wdata` into `cur_asid`, which holds its value otherwise. The write removes no entries: an address space that becomes current again hits on its old entries.
- R6: With `exc_mode` high, a lookup returns `res_valid` with `res_ppn` equal to `lk_vpn`, `res_prot` 0, and hit, miss and fault all low. Such a lookup leaves all ages unchanged.
- R7: Bit 0 of the protection field marks an entry supervisor-only. A lookup with `user_mode` high that matches such an entry gives `res_fault`, `res_ppn` 0 and `res_prot` set to the entry's bits. In supervisor mode the same lookup hits.
- R8: Two non-global entries with the same VPN but different ASID tags stay side by side. Each returns its own PPN and protection bits under its own ASID.
- R9: When several entries match, the one with the lowest index supplies the result.
- R10: `victim_idx` is the lowest-index valid non-global entry whose ASID tag differs from `cur_asid`, if such an entry exists.
- R11: Otherwise `victim_idx` is the entry with the largest age, with ties going to the lowest index. Each translated lookup adds 1 to every age, saturating at the maximum. The matched entry (hit or fault) and any written entry are reset to age 0. Invalid entries hold the maximum age.
- R12: A write through `wr_en` stores all fields at `wr_idx` and marks the entry valid. A lookup in the same cycle still sees the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Invalidate every entry |
| asid_we | input | 1 | Load the current-ASID register |
| asid_wdata | input | ASID_W | New current ASID |
| exc_mode | input | 1 | Exception mode: translation disabled |
| user_mode | input | 1 | Access comes from user mode |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| wr_en | input | 1 | Install an entry |
| wr_idx | input | log2(ENTRIES) | Entry index to write |
| wr_vpn | input | VPN_W | Virtual page of new entry |
| wr_ppn | input | PPN_W | Physical page of new entry |
| wr_asid | input | ASID_W | Address-space tag of new entry |
| wr_global | input | 1 | New entry ignores the ASID compare |
| wr_prot | input | PROT_W | Protection bits, bit 0 supervisor-only |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Translation succeeded |
| res_miss | output | 1 | No matching entry |
| res_fault | output | 1 | User access to supervisor-only page |
| res_ppn | output | PPN_W | Translated or passed-through page |
| res_prot | output | PROT_W | Protection bits of matched entry |
| victim_idx | output | log2(ENTRIES) | Suggested replacement index |
| cur_asid | output | ASID_W | Current address-space ID |

## Verification
The properties assume that `rst_n` is low through the first clock edge, and that `lk_req`, `asid_we` and `flush_all` are low during reset, so that no past value sampled after reset refers to an undriven request. The pass-through property compares VPN and PPN widths, so it assumes the two are equal, as in the default configuration. The stimulus changes inputs only at falling edges and holds every request for exactly one cycle. It issues writes, ASID loads and flushes only from the idle state. The one exception is the deliberate overlap of a write with a lookup or a flush, which R1 and R12 require.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    // positions inside the protection field
    localparam int PROT_SUPER_BIT = 0;
    localparam int PROT_WRITE_BIT = 1;
    localparam int PROT_EXEC_BIT  = 2;
endpackage

// File: rtl/tlb_first_one.sv
module tlb_first_one #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N      = 16,
    parameter int ASID_W = 8,
    parameter int VPN_W  = 20
) (
    input  logic [N-1:0]             ent_valid,
    input  logic [N-1:0]             ent_glob,
    input  logic [N-1:0][ASID_W-1:0] ent_asid,
    input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [ASID_W-1:0]        cur_asid,
    input  logic [VPN_W-1:0]         lk_vpn,
    output logic [N-1:0]             match_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic vpn_eq, asid_ok;
        assign vpn_eq  = ent_vpn[g] == lk_vpn;
        assign asid_ok = ent_glob[g] || (ent_asid[g] == cur_asid);
        assign match_vec[g] = ent_valid[g] && vpn_eq && asid_ok;
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N      = 16,
    parameter int ASID_W = 8,
    parameter int AGE_W  = 4,
    localparam int IW    = $clog2(N)
) (
    input  logic [N-1:0]             ent_valid,
    input  logic [N-1:0]             ent_glob,
    input  logic [N-1:0][ASID_W-1:0] ent_asid,
    input  logic [N-1:0][AGE_W-1:0]  ent_age,
    input  logic [ASID_W-1:0]        cur_asid,
    output logic [IW-1:0]            victim
);
    logic [N-1:0]     stale;
    logic             stale_found;
    logic [IW-1:0]    stale_idx;
    logic [IW-1:0]    old_idx;
    logic [AGE_W-1:0] old_age;

    for (genvar g = 0; g < N; g++) begin : g_stale
        assign stale[g] = ent_valid[g] && !ent_glob[g] && (ent_asid[g] != cur_asid);
    end

    tlb_first_one #(.N(N)) u_stale_pick (
        .vec   (stale),
        .found (stale_found),
        .idx   (stale_idx)
    );

    // oldest entry, strict compare keeps the lowest index on ties
    always_comb begin
        old_idx = '0;
        old_age = ent_age[0];
        for (int i = 1; i < N; i++) begin
            if (ent_age[i] > old_age) begin
                old_age = ent_age[i];
                old_idx = IW'(i);
            end
        end
    end

    assign victim = stale_found ? stale_idx : old_idx;
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ASID_W  = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int PROT_W  = 3,
    parameter int AGE_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_all,
    input  logic                       asid_we,
    input  logic [ASID_W-1:0]          asid_wdata,
    input  logic                       exc_mode,
    input  logic                       user_mode,
    input  logic                       lk_req,
    input  logic [VPN_W-1:0]           lk_vpn,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic [VPN_W-1:0]           wr_vpn,
    input  logic [PPN_W-1:0]           wr_ppn,
    input  logic [ASID_W-1:0]          wr_asid,
    input  logic                       wr_global,
    input  logic [PROT_W-1:0]          wr_prot,
    output logic                       res_valid,
    output logic                       res_hit,
    output logic                       res_miss,
    output logic                       res_fault,
    output logic [PPN_W-1:0]           res_ppn,
    output logic [PROT_W-1:0]          res_prot,
    output logic [$clog2(ENTRIES)-1:0] victim_idx,
    output logic [ASID_W-1:0]          cur_asid
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0]             glob;
        logic [ENTRIES-1:0][ASID_W-1:0] asid;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][PPN_W-1:0]  ppn;
        logic [ENTRIES-1:0][PROT_W-1:0] prot;
        logic [ENTRIES-1:0][AGE_W-1:0]  age;
        logic [ASID_W-1:0]              cur_asid;
        logic                           r_valid;
        logic                           r_hit;
        logic                           r_miss;
        logic                           r_fault;
        logic [PPN_W-1:0]               r_ppn;
        logic [PROT_W-1:0]              r_prot;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    logic [ENTRIES-1:0] match_vec;
    logic               m_found;
    logic [IDX_W-1:0]   m_idx;

    tlb_match #(
        .N      (ENTRIES),
        .ASID_W (ASID_W),
        .VPN_W  (VPN_W)
    ) u_match (
        .ent_valid (st_q.valid),
        .ent_glob  (st_q.glob),
        .ent_asid  (st_q.asid),
        .ent_vpn   (st_q.vpn),
        .cur_asid  (st_q.cur_asid),
        .lk_vpn    (lk_vpn),
        .match_vec (match_vec)
    );

    tlb_first_one #(.N(ENTRIES)) u_match_pick (
        .vec   (match_vec),
        .found (m_found),
        .idx   (m_idx)
    );

    tlb_victim #(
        .N      (ENTRIES),
        .ASID_W (ASID_W),
        .AGE_W  (AGE_W)
    ) u_victim (
        .ent_valid (st_q.valid),
        .ent_glob  (st_q.glob),
        .ent_asid  (st_q.asid),
        .ent_age   (st_q.age),
        .cur_asid  (st_q.cur_asid),
        .victim    (victim_idx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.r_valid = lk_req;
        st_d.r_hit   = 1'b0;
        st_d.r_miss  = 1'b0;
        st_d.r_fault = 1'b0;
        st_d.r_ppn   = '0;
        st_d.r_prot  = '0;

        if (lk_req) begin
            if (exc_mode) begin
                // translation off: page number passes through
                st_d.r_ppn = PPN_W'(lk_vpn);
            end else begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (st_q.age[i] != AGE_MAX) st_d.age[i] = st_q.age[i] + AGE_W'(1);
                end
                if (m_found) begin
                    st_d.age[m_idx] = '0;
                    st_d.r_prot     = st_q.prot[m_idx];
                    if (user_mode && st_q.prot[m_idx][PROT_SUPER_BIT]) begin
                        st_d.r_fault = 1'b1;
                    end else begin
                        st_d.r_hit = 1'b1;
                        st_d.r_ppn = st_q.ppn[m_idx];
                    end
                end else begin
                    st_d.r_miss = 1'b1;
                end
            end
        end

        if (asid_we) st_d.cur_asid = asid_wdata;

        if (flush_all) begin
            st_d.valid = '0;
            for (int i = 0; i < ENTRIES; i++) st_d.age[i] = AGE_MAX;
        end else if (wr_en) begin
            st_d.valid[wr_idx] = 1'b1;
            st_d.glob[wr_idx]  = wr_global;
            st_d.asid[wr_idx]  = wr_asid;
            st_d.vpn[wr_idx]   = wr_vpn;
            st_d.ppn[wr_idx]   = wr_ppn;
            st_d.prot[wr_idx]  = wr_prot;
            st_d.age[wr_idx]   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.age <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.r_valid;
    assign res_hit   = st_q.r_hit;
    assign res_miss  = st_q.r_miss;
    assign res_fault = st_q.r_fault;
    assign res_ppn   = st_q.r_ppn;
    assign res_prot  = st_q.r_prot;
    assign cur_asid  = st_q.cur_asid;
endmodule

// File: rtl/asid_tlb_sva.sv
module asid_tlb_sva #(
    parameter int ASID_W = 8,
    parameter int VPN_W  = 20,
    parameter int PPN_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_all,
    input logic              asid_we,
    input logic [ASID_W-1:0] asid_wdata,
    input logic              exc_mode,
    input logic              user_mode,
    input logic              lk_req,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic              res_valid,
    input logic              res_hit,
    input logic              res_miss,
    input logic              res_fault,
    input logic [PPN_W-1:0]  res_ppn,
    input logic [ASID_W-1:0] cur_asid
);
    assert_result_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> res_valid);
    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !res_valid);
    assert_single_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_hit, res_miss, res_fault}) <= 1);
    assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_hit || res_miss || res_fault));
    assert_flush_then_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all ##1 (lk_req && !exc_mode) |=> res_miss);
    assert_asid_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        asid_we |=> cur_asid == $past(asid_wdata));
    assert_asid_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !asid_we |=> $stable(cur_asid));
    assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && exc_mode) |=> (!res_hit && !res_miss && !res_fault
                                  && res_ppn == PPN_W'($past(lk_vpn))));
    assert_fault_user_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> $past(user_mode) && !$past(exc_mode));
endmodule

bind asid_tlb asid_tlb_sva #(
    .ASID_W (ASID_W),
    .VPN_W  (VPN_W),
    .PPN_W  (PPN_W)
) u_asid_tlb_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_all  (flush_all),
    .asid_we    (asid_we),
    .asid_wdata (asid_wdata),
    .exc_mode   (exc_mode),
    .user_mode  (user_mode),
    .lk_req     (lk_req),
    .lk_vpn     (lk_vpn),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_miss   (res_miss),
    .res_fault  (res_fault),
    .res_ppn    (res_ppn),
    .cur_asid   (cur_asid)
);

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int AMAX = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_all = 1'b0, asid_we = 1'b0, exc_mode = 1'b0, user_mode = 1'b0;
    logic [7:0]  asid_wdata = '0;
    logic        lk_req = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        wr_en = 1'b0, wr_global = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [19:0] wr_vpn = '0, wr_ppn = '0;
    logic [7:0]  wr_asid = '0;
    logic [2:0]  wr_prot = '0;
    logic        res_valid, res_hit, res_miss, res_fault;
    logic [19:0] res_ppn;
    logic [2:0]  res_prot;
    logic [3:0]  victim_idx;
    logic [7:0]  cur_asid;

    int checks = 0;
    int failures = 0;

    // reference model
    logic        m_valid [N];
    logic        m_glob  [N];
    logic [7:0]  m_asid  [N];
    logic [19:0] m_vpn   [N];
    logic [19:0] m_ppn   [N];
    logic [2:0]  m_prot  [N];
    int          m_age   [N];
    logic [7:0]  m_cur;

    always #(CLK_PERIOD / 2) clk = ~clk;

    asid_tlb i_asid_tlb (
        .clk(clk), .rst_n(rst_n), .flush_all(flush_all), .asid_we(asid_we),
        .asid_wdata(asid_wdata), .exc_mode(exc_mode), .user_mode(user_mode),
        .lk_req(lk_req), .lk_vpn(lk_vpn), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_asid(wr_asid), .wr_global(wr_global),
        .wr_prot(wr_prot), .res_valid(res_valid), .res_hit(res_hit),
        .res_miss(res_miss), .res_fault(res_fault), .res_ppn(res_ppn),
        .res_prot(res_prot), .victim_idx(victim_idx), .cur_asid(cur_asid)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0;
            m_age[i]   = AMAX;
        end
    endtask

    task automatic model_victim(output int v, output bit stale);
        int best;
        v = 0;
        stale = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_valid[i] && !m_glob[i] && m_asid[i] != m_cur) begin
                v = i;
                stale = 1'b1;
            end
        end
        if (!stale) begin
            best = m_age[0];
            for (int i = 1; i < N; i++) begin
                if (m_age[i] > best) begin
                    best = m_age[i];
                    v = i;
                end
            end
        end
    endtask

    task automatic check_victim();
        int v;
        bit s;
        model_victim(v, s);
        chk(victim_idx == 4'(v), s ? "R10" : "R11", "victim_idx",
            64'(victim_idx), 64'(v));
    endtask

    // expected packed result {valid,hit,miss,fault,ppn,prot}
    task automatic model_lookup(input logic [19:0] vpn, input logic usr, input logic exc,
                                output logic [26:0] exp, output string tag);
        int idx = -1;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_valid[i] && m_vpn[i] == vpn && (m_glob[i] || m_asid[i] == m_cur)) idx = i;
        end
        if (exc) begin
            exp = {4'b1000, vpn, 3'b000};
            tag = "R6";
        end else begin
            for (int i = 0; i < N; i++) if (m_age[i] < AMAX) m_age[i]++;
            if (idx < 0) begin
                exp = {4'b1010, 20'h0, 3'b000};
                tag = "R3";
            end else begin
                m_age[idx] = 0;
                if (usr && m_prot[idx][0]) begin
                    exp = {4'b1001, 20'h0, m_prot[idx]};
                    tag = "R7";
                end else begin
                    exp = {4'b1100, m_ppn[idx], m_prot[idx]};
                    tag = m_glob[idx] ? "R4" : "R3";
                end
            end
        end
    endtask

    function automatic logic [26:0] actual_res();
        return {res_valid, res_hit, res_miss, res_fault, res_ppn, res_prot};
    endfunction

    // all tasks start and end at a falling edge
    task automatic do_write(input logic [3:0] idx, input logic [19:0] vpn, input logic [19:0] ppn,
                            input logic [7:0] asid, input logic g, input logic [2:0] prot);
        wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_ppn = ppn;
        wr_asid = asid; wr_global = g; wr_prot = prot;
        @(posedge clk);
        m_valid[idx] = 1'b1; m_glob[idx] = g; m_asid[idx] = asid;
        m_vpn[idx] = vpn; m_ppn[idx] = ppn; m_prot[idx] = prot; m_age[idx] = 0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_asid(input logic [7:0] a);
        asid_we = 1'b1; asid_wdata = a;
        @(posedge clk);
        m_cur = a;
        @(negedge clk);
        asid_we = 1'b0;
        chk(cur_asid == a, "R5", "cur_asid", 64'(cur_asid), 64'(a));
    endtask

    task automatic lookup(input logic [19:0] vpn, input logic usr, input logic exc,
                          input string force_tag);
        logic [26:0] exp;
        string tag;
        model_lookup(vpn, usr, exc, exp, tag);
        if (force_tag != "") tag = force_tag;
        lk_req = 1'b1; lk_vpn = vpn; user_mode = usr; exc_mode = exc;
        @(posedge clk);
        @(negedge clk);
        lk_req = 1'b0; exc_mode = 1'b0; user_mode = 1'b0;
        chk(actual_res() == exp, tag, "lookup result", 64'(actual_res()), 64'(exp));
        @(posedge clk);
        @(negedge clk);
        chk(res_valid == 1'b0, "R2", "res_valid idle", 64'(res_valid), 64'h0);
        check_victim();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_clear();
        m_cur = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(res_valid == 1'b0, "R1", "reset res_valid", 64'(res_valid), 64'h0);
        chk(cur_asid == 8'h00, "R1", "reset cur_asid", 64'(cur_asid), 64'h0);
        chk(victim_idx == 4'd0, "R1", "reset victim", 64'(victim_idx), 64'h0);
        lookup(20'h00005, 1'b0, 1'b0, "R1");

        // populate: asid tags cycle 0..3, some global, odd entries supervisor-only
        set_asid(8'h03);
        for (int i = 0; i < N; i++) begin
            do_write(4'(i), 20'h00100 + 20'(i), 20'h00800 + 20'(3 * i),
                     8'(i % 4), (i % 5) == 0, 3'(i % 8));
            check_victim();
        end

        // sweep all address spaces, both privilege levels, all pages plus two misses (R3 R4 R5 R7)
        for (int a = 0; a < 4; a++) begin
            set_asid(8'(a));
            for (int u = 0; u < 2; u++) begin
                for (int v = 0; v < 18; v++) begin
                    lookup(20'h000FF + 20'(v), u[0], 1'b0, "");
                end
            end
        end

        // R6: pass-through in exception mode, ages untouched (victim checked by lookup)
        for (int v = 0; v < 6; v++) begin
            lookup(20'h00100 + 20'(v * 37), v[0], 1'b1, "R6");
        end

        // R8: same page under two address spaces
        do_write(4'd2, 20'h00200, 20'h0AAAA, 8'h01, 1'b0, 3'b000);
        do_write(4'd9, 20'h00200, 20'h0BBBB, 8'h02, 1'b0, 3'b010);
        set_asid(8'h01);
        lookup(20'h00200, 1'b0, 1'b0, "R8");
        set_asid(8'h02);
        lookup(20'h00200, 1'b0, 1'b0, "R8");
        set_asid(8'h01);
        lookup(20'h00200, 1'b1, 1'b0, "R8");
        check_victim();

        // R9: two global entries on one page, lowest index wins
        do_write(4'd7, 20'h00300, 20'h07777, 8'h05, 1'b1, 3'b100);
        do_write(4'd4, 20'h00300, 20'h04444, 8'h06, 1'b1, 3'b110);
        lookup(20'h00300, 1'b0, 1'b0, "R9");

        // R12: write and lookup of the same new page in one cycle
        begin
            logic [26:0] exp;
            string tag;
            model_lookup(20'h00400, 1'b0, 1'b0, exp, tag);
            lk_req = 1'b1; lk_vpn = 20'h00400;
            wr_en = 1'b1; wr_idx = 4'd5; wr_vpn = 20'h00400; wr_ppn = 20'h05555;
            wr_asid = 8'h01; wr_global = 1'b0; wr_prot = 3'b000;
            @(posedge clk);
            m_valid[5] = 1'b1; m_glob[5] = 1'b0; m_asid[5] = 8'h01;
            m_vpn[5] = 20'h00400; m_ppn[5] = 20'h05555; m_prot[5] = 3'b000; m_age[5] = 0;
            @(negedge clk);
            lk_req = 1'b0; wr_en = 1'b0;
            chk(actual_res() == exp, "R12", "lookup during write", 64'(actual_res()), 64'(exp));
        end
        lookup(20'h00400, 1'b0, 1'b0, "R12");

        // R1: flush wins over a simultaneous write
        flush_all = 1'b1;
        wr_en = 1'b1; wr_idx = 4'd3; wr_vpn = 20'h00600; wr_ppn = 20'h06666;
        wr_asid = 8'h01; wr_global = 1'b1; wr_prot = 3'b000;
        @(posedge clk);
        model_clear();
        @(negedge clk);
        flush_all = 1'b0; wr_en = 1'b0;
        chk(victim_idx == 4'd0, "R1", "victim after flush", 64'(victim_idx), 64'h0);
        lookup(20'h00600, 1'b0, 1'b0, "R1");
        lookup(20'h00105, 1'b0, 1'b0, "R1");

        // R11: all entries global, replacement by age
        for (int i = 0; i < N; i++) begin
            do_write(4'(i), 20'h00500 + 20'(i), 20'h0C000 + 20'(i), 8'(i), 1'b1, 3'b000);
        end
        check_victim();
        for (int k = 0; k < 12; k++) begin
            lookup(20'h00500 + 20'((k * 7) % N), 1'b0, 1'b0, "");
        end
        for (int k = 0; k < 20; k++) begin
            lookup(20'h00500, 1'b0, 1'b0, "R11");
        end
        chk(victim_idx == 4'd1, "R11", "saturated ages pick index 1", 64'(victim_idx), 64'h1);

        // R10: one stale non-global entry overrides age
        do_write(4'd12, 20'h00700, 20'h0D000, 8'h44, 1'b0, 3'b000);
        check_victim();
        chk(victim_idx == 4'd12, "R10", "stale entry chosen", 64'(victim_idx), 64'hC);
        set_asid(8'h44);
        check_victim();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule